// File: doc/BRIEF.md
# Rule Scheduler With Update Muxing

This block arbitrates a fixed set of guarded rules and commits their register updates. Each rule presents a readiness flag and a proposed value for every register it may write. From the readiness flags the block derives, in the same cycle, which rules fire. From the fire flags it builds a write enable and a next value for each shared register. The registers are held inside the block.

The pairwise conflict relation and the rule-to-register write map are elaboration-time bit matrices. Conflicting rules are merged into groups, the connected components of the conflict graph, and one rule at most fires per group. Rules in different groups fire together. When several fired rules write the same register, the committed value equals applying those rules one after another in ascending index order.

Top module: `rule_sched`

## Requirements
- R1: A fire output bit is high only in a cycle where the matching readiness input bit is high.
- R2: If any readiness bit is high, at least one fire bit is high in the same cycle.
- R3: Rules in the same connected component of the conflict graph (matrix bit i*N+j set means rules i and j conflict) never fire together. Within a component the lowest-indexed ready rule fires.
- R4: Ready rules in different components fire in the same cycle.
- R5: The write enable of register r is high exactly when some fired rule writes r (write map bit i*R+r set).
- R6: With one fired writer, register r takes that rule's proposed value (bits (i*R+r)*W upward of the data input) at the next rising clock edge.
- R7: With several fired writers of register r, the value loaded is that of the highest-indexed one, as if the fired rules ran one at a time in ascending order.
- R8: A register with no fired writer keeps its value.
- R9: Fire outputs depend only on the current readiness inputs, with no register in the path.
- R10: Reset low clears every register to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| can_fire_i | input | N | Readiness of each rule |
| upd_data_i | input | N*R*W | Proposed value of rule i for register r at bit offset (i*R+r)*W |
| fire_o | output | N | Rules firing in this cycle |
| wen_o | output | R | Write enable of each register |
| state_o | output | R*W | Register contents, register r at bit offset r*W |

## Verification
A wrong group mask or priority chain shows on fire_o in the very cycle the readiness pattern is applied, since the path is combinational. A wrong mux select or enable appears in state_o one edge later and persists until that register is written again, so each register is compared after every cycle. The bench sweeps every readiness pattern of a four-rule configuration with a three-rule component, an isolated rule sharing a register with that component, and a transitive conflict, so that grouping, cross-group concurrency and last-writer ordering are all visible.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  localparam int unsigned MAXN = 16;
  localparam int unsigned CW   = MAXN * MAXN;

  // reflexive-transitive closure of the conflict graph: bit i*n+j set when i,j share a group
  function automatic logic [CW-1:0] group_closure(input logic [CW-1:0] conf, input int n);
    logic [CW-1:0] m;
    m = conf;
    for (int i = 0; i < MAXN; i++)
      if (i < n) m[i*n+i] = 1'b1;
    for (int k = 0; k < MAXN; k++)
      for (int i = 0; i < MAXN; i++)
        for (int j = 0; j < MAXN; j++)
          if (k < n && i < n && j < n && m[i*n+k] && m[k*n+j])
            m[i*n+j] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rs_group_arbiter.sv
`timescale 1ns/1ps
module rs_group_arbiter #(
  parameter int unsigned N = 4,
  parameter logic [rs_pkg::CW-1:0] GRP = '0
) (
  input  logic [N-1:0] can_i,
  output logic [N-1:0] fire_o
);
  for (genvar i = 0; i < N; i++) begin : g_rule
    logic [N-1:0] lower_peer;
    for (genvar j = 0; j < N; j++) begin : g_peer
      if (j < i && GRP[i*N+j]) begin : g_on
        assign lower_peer[j] = 1'b1;
      end else begin : g_off
        assign lower_peer[j] = 1'b0;
      end
    end
    assign fire_o[i] = can_i[i] & ~|(can_i & lower_peer);
  end
endmodule

// File: rtl/rs_reg_mux.sv
`timescale 1ns/1ps
module rs_reg_mux #(
  parameter int unsigned N   = 4,
  parameter int unsigned R   = 2,
  parameter int unsigned W   = 8,
  parameter int unsigned COL = 0,
  parameter logic [N*R-1:0] WMAP = '0
) (
  input  logic [N-1:0]   fire_i,
  input  logic [N*W-1:0] data_i,
  output logic           wen_o,
  output logic [W-1:0]   nxt_o
);
  logic [N-1:0] writer;
  logic [N-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_wr
    if (WMAP[i*R+COL]) begin : g_on
      assign writer[i] = 1'b1;
    end else begin : g_off
      assign writer[i] = 1'b0;
    end
  end

  // a fired writer is overridden by any higher-indexed fired writer (later in sequence)
  for (genvar i = 0; i < N; i++) begin : g_sel
    logic [N-1:0] later;
    for (genvar j = 0; j < N; j++) begin : g_later
      if (j > i) begin : g_on
        assign later[j] = writer[j];
      end else begin : g_off
        assign later[j] = 1'b0;
      end
    end
    assign sel[i] = writer[i] & fire_i[i] & ~|(fire_i & later);
  end

  assign wen_o = |(fire_i & writer);

  always_comb begin
    nxt_o = '0;
    for (int i = 0; i < N; i++)
      nxt_o = nxt_o | ({W{sel[i]}} & data_i[i*W +: W]);
  end
endmodule

// File: rtl/rs_state_reg.sv
`timescale 1ns/1ps
module rs_state_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wen_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wen_i) q_o <= d_i;
  end
endmodule

// File: rtl/rule_sched.sv
`timescale 1ns/1ps
module rule_sched #(
  parameter int unsigned N = 4,
  parameter int unsigned R = 2,
  parameter int unsigned W = 8,
  parameter logic [N*N-1:0] CONFLICT = 16'h2092,
  parameter logic [N*R-1:0] WMAP     = 8'h6D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     can_fire_i,
  input  logic [N*R*W-1:0] upd_data_i,
  output logic [N-1:0]     fire_o,
  output logic [R-1:0]     wen_o,
  output logic [R*W-1:0]   state_o
);
  localparam int unsigned CW = rs_pkg::CW;
  localparam logic [CW-1:0] CONF_EXT = CW'(CONFLICT);
  localparam logic [CW-1:0] GRP = rs_pkg::group_closure(CONF_EXT, N);

  rs_group_arbiter #(.N(N), .GRP(GRP)) u_arb (
    .can_i (can_fire_i),
    .fire_o(fire_o)
  );

  for (genvar r = 0; r < R; r++) begin : g_reg
    logic [N*W-1:0] col_data;
    logic [W-1:0]   nxt;
    for (genvar i = 0; i < N; i++) begin : g_col
      assign col_data[i*W +: W] = upd_data_i[(i*R+r)*W +: W];
    end

    rs_reg_mux #(.N(N), .R(R), .W(W), .COL(r), .WMAP(WMAP)) u_mux (
      .fire_i(fire_o),
      .data_i(col_data),
      .wen_o (wen_o[r]),
      .nxt_o (nxt)
    );

    rs_state_reg #(.W(W)) u_q (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wen_i (wen_o[r]),
      .d_i   (nxt),
      .q_o   (state_o[r*W +: W])
    );
  end
endmodule

// File: rtl/rule_sched_checker.sv
`timescale 1ns/1ps
module rule_sched_checker #(
  parameter int unsigned N = 4,
  parameter int unsigned R = 2,
  parameter int unsigned W = 8,
  parameter logic [N*N-1:0] CONFLICT = '0,
  parameter logic [N*R-1:0] WMAP     = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     can_fire_i,
  input logic [N-1:0]     fire_o,
  input logic [R-1:0]     wen_o,
  input logic [R*W-1:0]   state_o
);
  localparam logic [rs_pkg::CW-1:0] GRP =
    rs_pkg::group_closure(rs_pkg::CW'(CONFLICT), N);

  p_fire_needs_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o & ~can_fire_i) == '0);

  p_liveness_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|can_fire_i) |-> (|fire_o));

  for (genvar i = 0; i < N; i++) begin : g_grp
    logic [N-1:0] row;
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign row[j] = GRP[i*N+j];
    end
    p_one_per_group_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(fire_o & row));
  end

  for (genvar r = 0; r < R; r++) begin : g_col
    logic [N-1:0] col;
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign col[i] = WMAP[i*R+r];
    end
    p_writer_enables_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((fire_o & col) != '0) |-> wen_o[r]);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_o[r] |=> $stable(state_o[r*W +: W]));
  end
endmodule

bind rule_sched rule_sched_checker #(
  .N(N), .R(R), .W(W), .CONFLICT(CONFLICT), .WMAP(WMAP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .can_fire_i(can_fire_i),
  .fire_o    (fire_o),
  .wen_o     (wen_o),
  .state_o   (state_o)
);

// File: tb/tb_rule_sched.sv
`timescale 1ns/1ps
module tb_rule_sched;
  localparam int N = 4;
  localparam int R = 2;
  localparam int W = 8;
  // conflicts: 0-1, 1-3 (so 0,1,3 share a group; 2 alone)
  localparam logic [N*N-1:0] CONF = 16'h2092;
  // writes: r0->reg0, r1->reg0+reg1, r2->reg1, r3->reg0
  localparam logic [N*R-1:0] WM   = 8'h6D;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N-1:0]     can = '0;
  logic [N*R*W-1:0] data = '0;
  logic [N-1:0]     fire;
  logic [R-1:0]     wen;
  logic [R*W-1:0]   state;

  int checks = 0;
  int failures = 0;
  int label [N];
  logic [W-1:0] mst [R];

  always #2 clk = ~clk;

  rule_sched #(.N(N), .R(R), .W(W), .CONFLICT(CONF), .WMAP(WM)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .can_fire_i(can), .upd_data_i(data),
    .fire_o(fire), .wen_o(wen), .state_o(state)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic check_state(input string tag);
    for (int r = 0; r < R; r++) begin
      checks++;
      if (state[r*W +: W] !== mst[r]) begin
        failures++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, r, state[r*W +: W], mst[r]);
      end
    end
  endtask

  task automatic step(input logic [N-1:0] pat, input int it);
    logic [N-1:0] efire;
    logic [R-1:0] ewen;
    @(negedge clk);
    check_state("R6 R7 R8");
    can = pat;
    for (int i = 0; i < N; i++)
      for (int r = 0; r < R; r++)
        data[(i*R+r)*W +: W] = W'(pat*29 + it*53 + i*7 + r*17 + 1);
    #1;
    efire = '0;
    for (int i = 0; i < N; i++) begin
      logic blocked = 1'b0;
      for (int j = 0; j < i; j++)
        if (label[j] == label[i] && pat[j]) blocked = 1'b1;
      efire[i] = pat[i] && !blocked;
    end
    // R1 R2 R3 R4 R9: fire is combinational, checked before any edge
    checks++;
    if (fire !== efire) begin
      failures++;
      $display("FAIL R1 R2 R3 R4 R9 can=%b actual=%b expected=%b", pat, fire, efire);
    end
    ewen = '0;
    for (int i = 0; i < N; i++)
      for (int r = 0; r < R; r++)
        if (efire[i] && WM[i*R+r]) begin
          ewen[r] = 1'b1;
          mst[r] = data[(i*R+r)*W +: W];
        end
    checks++;
    if (wen !== ewen) begin
      failures++;
      $display("FAIL R5 can=%b actual=%b expected=%b", pat, wen, ewen);
    end
  endtask

  initial begin
    // group labels by relaxation over the conflict matrix
    for (int i = 0; i < N; i++) label[i] = i;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (CONF[i*N+j]) begin
            if (label[j] < label[i]) label[i] = label[j];
            else label[j] = label[i];
          end
    for (int r = 0; r < R; r++) mst[r] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_state("R10 reset");
    rst_ni = 1'b1;

    for (int it = 0; it < 3; it++)
      for (int p = 0; p < (1 << N); p++)
        step(N'(p), it);
    // isolated rule with group winner, both writing reg1: highest index wins (R7)
    step(4'b0110, 7);
    step(4'b1100, 8);
    step(4'b0000, 9);
    @(negedge clk);
    check_state("R6 R7 R8");

    // asynchronous clear between edges
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    for (int r = 0; r < R; r++) mst[r] = '0;
    check_state("R10 async");
    @(negedge clk);
    rst_ni = 1'b1;
    step(4'b1111, 4);
    @(negedge clk);
    check_state("R6 R7");

    summary();
    $finish;
  end
endmodule